// File: doc/BRIEF.md
# Host-side inter-processor mailbox

A register-mapped mailbox that carries 32-bit messages from a coprocessor to a host CPU. The coprocessor pushes words through a push port (data plus a valid strobe) and sees a full flag. The host reaches the mailbox through a simple register bus: a word address, read and write strobes, write data, and read data. Read data is combinational and belongs to the cycle in which `rd_i` is high. Any side effect of that read, such as a pop or an error flag, takes effect at the next rising clock edge. Every access is a whole 32-bit word.

Behind the bus sit four decoded regions. A block of four adjacent words acts as the destructive read port. One word is a peek of the head entry. One word reports full, empty and fill level. One word is the configuration and interrupt register. It holds a has-data interrupt enable, a has-data pending flag and sticky error flags for underflow and overflow. The block drives a single level interrupt toward the host.

An empty mailbox never stalls the host. A read of the read port while empty returns the invalid-data word 0xFFFFFFFF and raises a sticky underflow flag. A push while full is dropped and raises a sticky overflow flag. Software clears the error flags by writing the configuration register.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset the status word reads 0x40000000, the config word reads 0, a peek reads 0xFFFFFFFF, and `full_o` and `irq_o` are 0.
- R2: Pushed words come back in push order through reads of any of word addresses 0x20, 0x21, 0x22 and 0x23. Each read of a non-empty mailbox removes exactly one word.
- R3: A read of word address 0x24 returns the head word without removing it. It returns 0xFFFFFFFF when the mailbox is empty.
- R4: The status word at word address 0x26 has the following fields. Bit 31 is 1 exactly when 8 words are held. Bit 30 is 1 exactly when none are held. Bits 7:0 give the number held. All other bits are 0.
- R5: A read-port read while the mailbox is empty returns 0xFFFFFFFF and leaves the contents unchanged. It also sets the sticky underflow flag, bit 10 of config.
- R6: `full_o` is 1 exactly when 8 words are held. A push while full is dropped unless a read-port pop happens in the same cycle. A dropped push sets the sticky overflow flag, bit 9 of config. The contents stay as they were.
- R7: In the config word at word address 0x27, bit 4 reads 1 whenever the mailbox is not empty. `irq_o` equals config bit 0 AND config bit 4.
- R8: A write to config loads bit 0 from write-data bit 0 and ignores all other write-data bits. It clears bits 9 and 10. Bit 8 always reads 0. An error event in the same cycle as the write leaves its flag set.
- R9: Reads of word addresses outside 0x20 to 0x24, 0x26 and 0x27 return 0. Writes to any address other than 0x27, the status word included, change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Host word address |
| rd_i | input | 1 | Host read strobe, ignored while wr_i is high |
| wr_i | input | 1 | Host write strobe |
| wdata_i | input | 32 | Host write data |
| rdata_o | output | 32 | Host read data for the current address |
| push_i | input | 1 | Producer push strobe |
| push_data_i | input | 32 | Producer push word |
| full_o | output | 1 | Mailbox holds its full depth |
| irq_o | output | 1 | Has-data interrupt toward the host |

## Verification
The hardest case to reach from the ports is a mailbox that is already full while a producer push and a host pop land in the same cycle. In that case the push must be accepted, and no overflow may be recorded. A close second is an error event that coincides with a config write, where the new flag must survive the clear. Directed sequences fill the mailbox to its limit and then issue these coincident strobes. After that, constrained random traffic alternates between push-heavy and read-heavy phases, so the fill level keeps swinging between empty and full. During that traffic, config writes, peeks and unmapped accesses are mixed in at random.

// File: rtl/ipc_mbox_pkg.sv
package ipc_mbox_pkg;
  localparam int WORD_W = 32;
  localparam logic [WORD_W-1:0] INVALID_WORD = 32'hFFFF_FFFF;

  // host word addresses
  localparam int RD_LO_A = 'h20;
  localparam int RD_HI_A = 'h23;
  localparam int PEEK_A  = 'h24;
  localparam int STAT_A  = 'h26;
  localparam int CFG_A   = 'h27;

  // status fields
  localparam int ST_FULL_B  = 31;
  localparam int ST_EMPTY_B = 30;
  localparam int LVL_W      = 8;

  // config fields
  localparam int CFG_EN_B   = 0;
  localparam int CFG_PEND_B = 4;
  localparam int ERR_OWN_B  = 8;
  localparam int ERR_OVF_B  = 9;
  localparam int ERR_UNF_B  = 10;
endpackage

// File: rtl/ipc_mbox_fifo.sv
module ipc_mbox_fifo #(
  parameter int DEPTH = 8,
  parameter int DW    = 32,
  parameter int CW    = $clog2(DEPTH + 1),
  parameter logic [DW-1:0] EMPTY_WORD = '1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] data_i,
  input  logic          pop_i,
  output logic [DW-1:0] head_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o,
  output logic          drop_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0] slot_q [DEPTH];
  logic [PW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_pop  = pop_i && !empty_o;
  // a pop in the same cycle frees a slot for the push
  assign do_push = push_i && (!full_o || do_pop);
  assign drop_o  = push_i && full_o && !do_pop;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                slot_q[g] <= EMPTY_WORD;
      else if (do_push && wr_ptr_q == PW'(g))     slot_q[g] <= data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (do_pop)  rd_ptr_q <= ptr_inc(rd_ptr_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign head_o  = empty_o ? EMPTY_WORD : slot_q[rd_ptr_q];
  assign count_o = cnt_q;
endmodule

// File: rtl/ipc_mbox_csr.sv
module ipc_mbox_csr
  import ipc_mbox_pkg::*;
#(
  parameter int AW = 8,
  parameter int CW = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AW-1:0]     addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic              wen_bit_i,
  input  logic [WORD_W-1:0] head_i,
  input  logic [CW-1:0]     count_i,
  input  logic              full_i,
  input  logic              empty_i,
  input  logic              drop_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic              pop_o,
  output logic              irq_o
);
  logic hit_rd, hit_peek, hit_stat, hit_cfg;
  logic rd_act, cfg_wr, unf_evt;
  logic en_q, ovf_q, unf_q;
  logic [WORD_W-1:0] stat_w, cfg_w;

  assign hit_rd   = (addr_i >= AW'(RD_LO_A)) && (addr_i <= AW'(RD_HI_A));
  assign hit_peek = (addr_i == AW'(PEEK_A));
  assign hit_stat = (addr_i == AW'(STAT_A));
  assign hit_cfg  = (addr_i == AW'(CFG_A));

  // write strobe wins over a simultaneous read
  assign rd_act  = rd_i && !wr_i;
  assign cfg_wr  = wr_i && hit_cfg;
  assign pop_o   = rd_act && hit_rd;
  assign unf_evt = pop_o && empty_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      if (cfg_wr) en_q <= wen_bit_i;
      ovf_q <= (ovf_q && !cfg_wr) || drop_i;
      unf_q <= (unf_q && !cfg_wr) || unf_evt;
    end
  end

  always_comb begin
    stat_w = '0;
    stat_w[ST_FULL_B]  = full_i;
    stat_w[ST_EMPTY_B] = empty_i;
    stat_w[LVL_W-1:0]  = LVL_W'(count_i);
  end

  always_comb begin
    cfg_w = '0;
    cfg_w[CFG_EN_B]   = en_q;
    cfg_w[CFG_PEND_B] = !empty_i;
    cfg_w[ERR_OWN_B]  = 1'b0;
    cfg_w[ERR_OVF_B]  = ovf_q;
    cfg_w[ERR_UNF_B]  = unf_q;
  end

  always_comb begin
    rdata_o = '0;
    if (hit_rd || hit_peek) rdata_o = head_i;
    else if (hit_stat)      rdata_o = stat_w;
    else if (hit_cfg)       rdata_o = cfg_w;
  end

  assign irq_o = en_q && !empty_i;
endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
  import ipc_mbox_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AW-1:0]     addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o,
  input  logic              push_i,
  input  logic [WORD_W-1:0] push_data_i,
  output logic              full_o,
  output logic              irq_o
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [WORD_W-1:0] head_w;
  logic [CW-1:0]     fifo_cnt;
  logic              empty_w, drop_w, pop_w;
  logic              unused_wdata;

  assign unused_wdata = ^wdata_i[WORD_W-1:1];

  ipc_mbox_fifo #(
    .DEPTH(DEPTH), .DW(WORD_W), .CW(CW), .EMPTY_WORD(INVALID_WORD)
  ) u_fifo (
    .clk_i, .rst_ni,
    .push_i, .data_i(push_data_i), .pop_i(pop_w),
    .head_o(head_w), .count_o(fifo_cnt), .full_o,
    .empty_o(empty_w), .drop_o(drop_w)
  );

  ipc_mbox_csr #(.AW(AW), .CW(CW)) u_csr (
    .clk_i, .rst_ni,
    .addr_i, .rd_i, .wr_i, .wen_bit_i(wdata_i[0]),
    .head_i(head_w), .count_i(fifo_cnt), .full_i(full_o),
    .empty_i(empty_w), .drop_i(drop_w),
    .rdata_o, .pop_o(pop_w), .irq_o
  );
endmodule

// File: rtl/ipc_mailbox_chk.sv
module ipc_mailbox_chk #(
  parameter int DEPTH = 8,
  parameter int AW    = 8,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [AW-1:0] addr_i,
  input logic          rd_i,
  input logic          wr_i,
  input logic          push_i,
  input logic          full_o,
  input logic          irq_o,
  input logic [31:0]   rdata_o,
  input logic [CW-1:0] count_i,
  input logic          pop_i
);
  logic rd_port;
  assign rd_port = rd_i && !wr_i && addr_i >= AW'('h20) && addr_i <= AW'('h23);

  // R6
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && push_i && !pop_i |=> full_o && $stable(count_i));

  // R5
  empty_read_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_port && count_i == '0 |-> rdata_o == 32'hFFFF_FFFF);

  // R5
  empty_read_keeps_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_port && count_i == '0 && !push_i |=> count_i == '0);

  // R2
  pop_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_port && count_i != '0 && !push_i |=> count_i == $past(count_i) - 1'b1);

  // R7
  irq_needs_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> count_i != '0);

  // R4
  level_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_i <= CW'(DEPTH));
endmodule

bind ipc_mailbox ipc_mailbox_chk #(.DEPTH(DEPTH), .AW(AW)) u_chk (
  .clk_i, .rst_ni, .addr_i, .rd_i, .wr_i, .push_i, .full_o, .irq_o, .rdata_o,
  .count_i(fifo_cnt), .pop_i(pop_w)
);

// File: tb/ipc_mailbox_tb.sv
module ipc_mailbox_tb;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  addr_i = '0;
  logic        rd_i = 1'b0, wr_i = 1'b0, push_i = 1'b0;
  logic [31:0] wdata_i = '0, push_data_i = '0;
  logic [31:0] rdata_o;
  logic        full_o, irq_o;

  int checks = 0, failures = 0;

  logic [31:0] mq[$];
  logic        m_en = 0, m_ovf = 0, m_unf = 0;

  always #2 clk = ~clk;

  ipc_mailbox u_dut (
    .clk_i(clk), .rst_ni, .addr_i, .rd_i, .wr_i, .wdata_i, .rdata_o,
    .push_i, .push_data_i, .full_o, .irq_o
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_stat();
    int n = mq.size();
    return {n == DEPTH, n == 0, 22'b0, 8'(n)};
  endfunction

  function automatic logic [31:0] exp_cfg();
    return {21'b0, m_unf, m_ovf, 1'b0, 3'b0, mq.size() > 0, 3'b0, m_en};
  endfunction

  function automatic logic [31:0] exp_rd(input logic [7:0] a);
    if ((a >= 8'h20 && a <= 8'h24)) return (mq.size() > 0) ? mq[0] : 32'hFFFF_FFFF;
    if (a == 8'h26) return exp_stat();
    if (a == 8'h27) return exp_cfg();
    return 32'h0;
  endfunction

  function automatic string tag_of(input logic [7:0] a);
    if (a >= 8'h20 && a <= 8'h23) return (mq.size() > 0) ? "R2" : "R5";
    if (a == 8'h24) return "R3";
    if (a == 8'h26) return "R4";
    if (a == 8'h27) return "R7";
    return "R9";
  endfunction

  task automatic op(input bit p, input logic [31:0] pd, input bit r, input bit w,
                    input logic [7:0] a, input logic [31:0] wd);
    bit pop, dopush;
    @(negedge clk);
    push_i = p; push_data_i = pd; rd_i = r; wr_i = w; addr_i = a; wdata_i = wd;
    #1;
    if (r && !w) chk(rdata_o === exp_rd(a), tag_of(a), rdata_o, exp_rd(a));
    chk(full_o === (mq.size() == DEPTH), "R6", {31'b0, full_o}, {31'b0, mq.size() == DEPTH});
    chk(irq_o === (m_en && mq.size() > 0), "R7", {31'b0, irq_o}, {31'b0, m_en && mq.size() > 0});
    // model update for this edge
    pop    = r && !w && a >= 8'h20 && a <= 8'h23 && mq.size() > 0;
    dopush = p && (mq.size() < DEPTH || pop);
    if (w && a == 8'h27) begin
      m_en = wd[0]; m_ovf = 0; m_unf = 0;
    end
    if (r && !w && a >= 8'h20 && a <= 8'h23 && mq.size() == 0) m_unf = 1;
    if (p && !dopush) m_ovf = 1;
    if (pop) void'(mq.pop_front());
    if (dopush) mq.push_back(pd);
    @(posedge clk); #1;
    push_i = 0; rd_i = 0; wr_i = 0;
  endtask

  task automatic rd(input logic [7:0] a); op(0, 0, 1, 0, a, 0); endtask
  task automatic wr(input logic [7:0] a, input logic [31:0] d); op(0, 0, 0, 1, a, d); endtask
  task automatic push(input logic [31:0] d); op(1, d, 0, 0, 8'h00, 0); endtask

  initial begin
    #(4 * 200000);
    failures++;
    $display("FAIL watchdog actual=%08h expected=%08h", 32'h1, 32'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] alist [10] = '{8'h20, 8'h21, 8'h22, 8'h23, 8'h24, 8'h26, 8'h27, 8'h25, 8'h10, 8'h30};
    void'($urandom(32'h5eed_1234));
    #9 rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    addr_i = 8'h26; #1; chk(rdata_o === 32'h4000_0000, "R1", rdata_o, 32'h4000_0000);
    addr_i = 8'h27; #1; chk(rdata_o === 32'h0, "R1", rdata_o, 32'h0);
    addr_i = 8'h24; #1; chk(rdata_o === 32'hFFFF_FFFF, "R1", rdata_o, 32'hFFFF_FFFF);
    chk({full_o, irq_o} === 2'b00, "R1", {30'b0, full_o, irq_o}, 32'h0);

    // R5 empty read, R8 clear
    rd(8'h22); rd(8'h27); rd(8'h26);
    wr(8'h27, 32'hFFFF_FFFE); rd(8'h27);
    // R7 enable, irq follows data
    wr(8'h27, 32'h1); rd(8'h27);
    push(32'hA000_0001); rd(8'h27); rd(8'h24); rd(8'h24); rd(8'h26);
    // R6 fill to full, overflow, coincident pop and push
    for (int i = 2; i <= DEPTH; i++) push(32'hA000_0000 + i);
    rd(8'h26); push(32'hDEAD_BEEF); rd(8'h27); rd(8'h26);
    op(1, 32'hB000_0009, 1, 0, 8'h21, 0); rd(8'h26); rd(8'h27);
    // R8 error event coincident with config write
    op(1, 32'hCAFE_0000, 0, 1, 8'h27, 32'h1); rd(8'h27);
    // R9 unmapped and read-only writes
    wr(8'h26, 32'hFFFF_FFFF); wr(8'h30, 32'hFFFF_FFFF); wr(8'h20, 32'h0);
    rd(8'h26); rd(8'h27); rd(8'h30); rd(8'h25);
    // R2 drain through every read-port alias
    for (int i = 0; i < DEPTH; i++) rd(8'h20 + 8'(i % 4));
    rd(8'h26); rd(8'h23); rd(8'h24); rd(8'h27);
    wr(8'h27, 32'h0);

    // random traffic, alternating fill phases
    for (int i = 0; i < 4000; i++) begin
      bit push_heavy = ((i / 150) % 2) == 0;
      bit p = ($urandom % 4) < (push_heavy ? 3 : 1);
      bit w = ($urandom % 16) == 0;
      bit r = !w && (($urandom % 4) < (push_heavy ? 1 : 3));
      logic [7:0] a = alist[$urandom % 10];
      if (w && ($urandom % 2)) a = 8'h27;
      op(p, $urandom, r, w, a, $urandom);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule